// File: doc/BRIEF.md
# Two-Bank SDRAM Command Front End

This block is the device-side command front end of a synchronous DRAM with two banks. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable inputs, together with the clock-enable input, a bank-select bit and an 11-bit address. From these it decodes activate, precharge, read and write commands. It keeps an idle or active flag and an open row for each bank. It also decides whether the internal clock runs or is suspended, and whether the device may enter power-down.

All results are registered. A downstream array controller sees a command code, the bank, row and column fields, and a flag bit. The flag means auto-precharge for column accesses and means all banks for precharge. It also sees the per-bank state, an illegal-access pulse and the power-down status. Burst sequencing, data, the mode register and analog timing live in other blocks.

Top module: `sdram_cmd_front`

## Requirements
- R1: Inputs are sampled only on the rising edge, and every result is visible after that edge. Synchronous active-high reset leaves both banks idle, open rows 0, command code NOP (0), all fields 0, no error and no power-down.
- R2: A processed edge with chip-select high yields NOP (0) and changes no bank state, whatever the other strobes are.
- R3: Chip-select low, row-strobe low, column-strobe high and write-enable high is activate (code 1). It makes the bank named by bank-select active and stores address bits 10..0 as that bank's open row.
- R4: Chip-select low, row-strobe low, column-strobe high and write-enable low is precharge (code 2). With address bit 10 low, only the selected bank goes idle, and the other bank keeps its state.
- R5: A precharge with address bit 10 high sends both banks idle and sets the flag output.
- R6: Chip-select low, row-strobe high and column-strobe low to an active bank is read (code 3) when write-enable is high, and write (code 4) when it is low. The column output carries address bits 7..0 and the flag carries address bit 10. On every processed edge the bank, row and column outputs load from the sampled bank-select and address. The flag is 0 for every command other than precharge, read and write.
- R7: An edge is processed only if clock-enable was high at the previous edge. The edge at which clock-enable is first sampled low is still processed. After that, all outputs and bank state hold until one edge after clock-enable is sampled high again.
- R8: Power-down is set at an edge where clock-enable is sampled low, clock-enable was high at the previous edge, and both banks are idle after that edge's command. It clears at the first edge where clock-enable is sampled high. It is never set while a bank is active.
- R9: A read or write to an idle bank gives code NOP, pulses the illegal-access output until the next processed edge, gives flag 0 and leaves both banks unchanged.
- R10: Any other pattern with chip-select low decodes as NOP. This covers row-strobe and column-strobe both low, and both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| bank_sel | input | 1 | Bank select |
| addr | input | 11 | Row or column address, bit 10 is the flag bit |
| cmd_code | output | 3 | Decoded command: 0 NOP, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_bank | output | 1 | Registered bank select |
| cmd_row | output | 11 | Registered address as row |
| cmd_col | output | 8 | Registered address bits 7..0 as column |
| cmd_flag | output | 1 | Auto-precharge or precharge-all flag |
| illegal_err | output | 1 | Read or write aimed at an idle bank |
| bank_active | output | 2 | Per-bank active state, bit i for bank i |
| open_row | output | 22 | Open rows, bank i at bits 11*i+10..11*i |
| power_down | output | 1 | Power-down status |

## Verification
The bench targets the edge where clock-enable first falls. A design that froze one cycle early would drop the activate issued on that edge, and one that froze one cycle late would accept a precharge-all while suspended. It issues precharge with bit 10 high and low. A design that decoded the wrong bit would close the wrong number of banks. It also sends column accesses to closed banks, which a careless decoder would report as reads and writes. Finally it drops clock-enable both with a bank open and with both idle, to catch power-down entry that ignores bank state. Random traffic then exercises mixed sequences against the cycle model.

// File: rtl/sdram_front_pkg.sv
package sdram_front_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_front_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e raw_cmd
);
  always_comb begin
    raw_cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  raw_cmd = CMD_ACT;
        3'b010:  raw_cmd = CMD_PRE;
        3'b101:  raw_cmd = CMD_RD;
        3'b100:  raw_cmd = CMD_WR;
        default: raw_cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic idle_after,
  output logic run,
  output logic pd
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q <= 1'b1;
      pd    <= 1'b0;
    end else begin
      cke_q <= cke;
      if (cke)
        pd <= 1'b0;
      else if (cke_q && idle_after)
        pd <= 1'b1;
    end
  end

  assign run = cke_q;
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_front_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int BANK_W = 1,
  parameter int ROW_W  = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  cmd_e                   cmd,
  input  logic [BANK_W-1:0]      bank,
  input  logic [ROW_W-1:0]       row,
  input  logic                   pre_all,
  output logic [NBANK-1:0]       act_q,
  output logic [NBANK-1:0]       act_nxt,
  output logic [NBANK*ROW_W-1:0] rows_q
);
  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    logic             hit;
    logic [ROW_W-1:0] row_r;

    assign hit = (bank == BANK_W'(gi));

    always_comb begin
      act_nxt[gi] = act_q[gi];
      if (run) begin
        if (cmd == CMD_ACT && hit)
          act_nxt[gi] = 1'b1;
        else if (cmd == CMD_PRE && (pre_all || hit))
          act_nxt[gi] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[gi] <= 1'b0;
        row_r     <= '0;
      end else begin
        act_q[gi] <= act_nxt[gi];
        if (run && cmd == CMD_ACT && hit)
          row_r <= row;
      end
    end

    assign rows_q[gi*ROW_W +: ROW_W] = row_r;
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_front_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int FLAG_BIT = 10,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic                   cke,
  input  logic [BANK_W-1:0]      bank_sel,
  input  logic [ROW_W-1:0]       addr,
  output logic [2:0]             cmd_code,
  output logic [BANK_W-1:0]      cmd_bank,
  output logic [ROW_W-1:0]       cmd_row,
  output logic [COL_W-1:0]       cmd_col,
  output logic                   cmd_flag,
  output logic                   illegal_err,
  output logic [NBANK-1:0]       bank_active,
  output logic [NBANK*ROW_W-1:0] open_row,
  output logic                   power_down
);
  cmd_e             raw_cmd;
  cmd_e             eff_cmd;
  logic             bad_access;
  logic             run_q;
  logic [NBANK-1:0] act_q;
  logic [NBANK-1:0] act_nxt;

  sdram_cmd_decode u_dec (
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .raw_cmd (raw_cmd)
  );

  // A column access to a closed bank is demoted to a no-op.
  always_comb begin
    bad_access = (raw_cmd == CMD_RD || raw_cmd == CMD_WR) && !act_q[bank_sel];
    eff_cmd    = bad_access ? CMD_NOP : raw_cmd;
  end

  sdram_bank_track #(
    .NBANK  (NBANK),
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W)
  ) u_banks (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .cmd     (eff_cmd),
    .bank    (bank_sel),
    .row     (addr),
    .pre_all (addr[FLAG_BIT]),
    .act_q   (act_q),
    .act_nxt (act_nxt),
    .rows_q  (open_row)
  );

  sdram_cke_ctrl u_cke (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .idle_after (act_nxt == '0),
    .run        (run_q),
    .pd         (power_down)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code    <= CMD_NOP;
      cmd_bank    <= '0;
      cmd_row     <= '0;
      cmd_col     <= '0;
      cmd_flag    <= 1'b0;
      illegal_err <= 1'b0;
    end else if (run_q) begin
      cmd_code    <= eff_cmd;
      cmd_bank    <= bank_sel;
      cmd_row     <= addr;
      cmd_col     <= addr[COL_W-1:0];
      cmd_flag    <= (eff_cmd == CMD_PRE || eff_cmd == CMD_RD || eff_cmd == CMD_WR)
                     && addr[FLAG_BIT];
      illegal_err <= bad_access;
    end
  end

  assign bank_active = act_q;
endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
  parameter int NBANK  = 2,
  parameter int BANK_W = 1,
  parameter int ROW_W  = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [BANK_W-1:0]      bank_sel,
  input logic [2:0]             cmd_code,
  input logic                   illegal_err,
  input logic [NBANK-1:0]       bank_active,
  input logic [NBANK*ROW_W-1:0] open_row,
  input logic                   power_down
);
  a_r2_cs_masks: assert property (@(posedge clk) disable iff (rst)
    (run && cs_n) |=> (cmd_code == 3'd0 && !illegal_err && $stable(bank_active)));

  a_r3_act_opens: assert property (@(posedge clk) disable iff (rst)
    (run && !cs_n && !ras_n && cas_n && we_n) |=> bank_active[$past(bank_sel)]);

  a_r6_rw_code: assert property (@(posedge clk) disable iff (rst)
    (run && !cs_n && ras_n && !cas_n && bank_active[bank_sel])
      |=> (cmd_code == ($past(we_n) ? 3'd3 : 3'd4)));

  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(bank_active) && $stable(cmd_code) && $stable(open_row)
              && $stable(illegal_err)));

  a_r8_pd_idle: assert property (@(posedge clk) disable iff (rst)
    power_down |-> (bank_active == '0));

  a_r9_idle_access: assert property (@(posedge clk) disable iff (rst)
    (run && !cs_n && ras_n && !cas_n && !bank_active[bank_sel])
      |=> (illegal_err && cmd_code == 3'd0 && $stable(bank_active)));
endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(
  .NBANK  (NBANK),
  .BANK_W (BANK_W),
  .ROW_W  (ROW_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run         (run_q),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .bank_sel    (bank_sel),
  .cmd_code    (cmd_code),
  .illegal_err (illegal_err),
  .bank_active (bank_active),
  .open_row    (open_row),
  .power_down  (power_down)
);

// File: tb/sim_sdram_cmd_front.sv
module sim_sdram_cmd_front;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic        bank_sel = 1'b0;
  logic [10:0] addr = '0;
  logic [2:0]  cmd_code;
  logic        cmd_bank;
  logic [10:0] cmd_row;
  logic [7:0]  cmd_col;
  logic        cmd_flag, illegal_err, power_down;
  logic [1:0]  bank_active;
  logic [21:0] open_row;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_front u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .bank_sel(bank_sel), .addr(addr), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_flag(cmd_flag),
    .illegal_err(illegal_err), .bank_active(bank_active), .open_row(open_row),
    .power_down(power_down)
  );

  // Behavioural reference model
  int          m_cmd, m_bank, m_row, m_col, m_flag, m_err, m_pd, m_ckeq;
  int          m_act[2];
  int          m_open[2];

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 0; m_bank = 0; m_row = 0; m_col = 0; m_flag = 0; m_err = 0;
      m_pd = 0; m_ckeq = 1;
      m_act[0] = 0; m_act[1] = 0; m_open[0] = 0; m_open[1] = 0;
    end else begin
      if (m_ckeq == 1) begin
        int c;
        c = 0;
        if (cs_n == 0) begin
          if (ras_n == 0 && cas_n == 1) c = (we_n == 1) ? 1 : 2;
          else if (ras_n == 1 && cas_n == 0) c = (we_n == 1) ? 3 : 4;
        end
        m_err = 0;
        if ((c == 3 || c == 4) && m_act[bank_sel] == 0) begin
          c = 0;
          m_err = 1;
        end
        if (c == 1) begin
          m_act[bank_sel] = 1;
          m_open[bank_sel] = int'(addr);
        end
        if (c == 2) begin
          if (addr[10]) begin m_act[0] = 0; m_act[1] = 0; end
          else m_act[bank_sel] = 0;
        end
        m_cmd = c;
        m_bank = int'(bank_sel);
        m_row = int'(addr);
        m_col = int'(addr[7:0]);
        m_flag = (c >= 2 && addr[10]) ? 1 : 0;
      end
      if (cke) m_pd = 0;
      else if (m_ckeq == 1 && m_act[0] == 0 && m_act[1] == 0) m_pd = 1;
      m_ckeq = int'(cke);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "cmd_code", int'(cmd_code), m_cmd);
    chk(tag, "cmd_bank", int'(cmd_bank), m_bank);
    chk(tag, "cmd_row", int'(cmd_row), m_row);
    chk(tag, "cmd_col", int'(cmd_col), m_col);
    chk(tag, "cmd_flag", int'(cmd_flag), m_flag);
    chk(tag, "illegal_err", int'(illegal_err), m_err);
    chk(tag, "bank_active0", int'(bank_active[0]), m_act[0]);
    chk(tag, "bank_active1", int'(bank_active[1]), m_act[1]);
    chk(tag, "open_row0", int'(open_row[10:0]), m_open[0]);
    chk(tag, "open_row1", int'(open_row[21:11]), m_open[1]);
    chk(tag, "power_down", int'(power_down), m_pd);
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic cs, input logic ras, input logic cas, input logic we,
                      input logic ck, input logic bs, input logic [10:0] a,
                      input string tag);
    cs_n = cs; ras_n = ras; cas_n = cas; we_n = we; cke = ck; bank_sel = bs; addr = a;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 1'b0;
    step(1, 1, 1, 1, 1, 0, 11'h000, "R1");
    chk("R1", "reset bank_active", int'(bank_active), 0);
    // R3: open both banks
    step(0, 0, 1, 1, 1, 0, 11'h2AB, "R3");
    chk("R3", "act code", int'(cmd_code), 1);
    step(0, 0, 1, 1, 1, 1, 11'h155, "R3");
    chk("R3", "bank1 row", int'(open_row[21:11]), 11'h155);
    // R6: read and write with and without flag
    step(0, 1, 0, 1, 1, 0, 11'h03C, "R6");
    chk("R6", "read code", int'(cmd_code), 3);
    step(0, 1, 0, 0, 1, 1, 11'h4A5, "R6");
    chk("R6", "write flag", int'(cmd_flag), 1);
    chk("R6", "write col", int'(cmd_col), 8'hA5);
    // R2: chip-select high masks a precharge-all
    step(1, 0, 1, 0, 1, 0, 11'h400, "R2");
    chk("R2", "masked banks", int'(bank_active), 3);
    // R10: other patterns
    step(0, 0, 0, 1, 1, 0, 11'h000, "R10");
    chk("R10", "refresh-like nop", int'(cmd_code), 0);
    step(0, 1, 1, 0, 1, 1, 11'h7FF, "R10");
    // R4: single-bank precharge
    step(0, 0, 1, 0, 1, 0, 11'h000, "R4");
    chk("R4", "banks after pre0", int'(bank_active), 2);
    // R9: read to idle bank 0
    step(0, 1, 0, 1, 1, 0, 11'h411, "R9");
    chk("R9", "err pulse", int'(illegal_err), 1);
    chk("R9", "err flag", int'(cmd_flag), 0);
    step(0, 1, 0, 0, 1, 0, 11'h011, "R9");
    step(1, 1, 1, 1, 1, 0, 11'h000, "R9");
    chk("R9", "err cleared", int'(illegal_err), 0);
    // R5: precharge all
    step(0, 0, 1, 1, 1, 0, 11'h123, "R5");
    step(0, 0, 1, 0, 1, 1, 11'h400, "R5");
    chk("R5", "all idle", int'(bank_active), 0);
    // R7: suspension with a bank opened on the falling-CKE edge
    step(0, 0, 1, 1, 0, 1, 11'h0F0, "R7");
    chk("R7", "edge still processed", int'(bank_active), 2);
    step(0, 0, 1, 0, 0, 0, 11'h400, "R7");
    step(0, 1, 0, 1, 0, 1, 11'h400, "R7");
    chk("R7", "frozen banks", int'(bank_active), 2);
    chk("R8", "no pd while active", int'(power_down), 0);
    step(0, 0, 1, 0, 1, 0, 11'h400, "R7");
    chk("R7", "still frozen on cke rise", int'(bank_active), 2);
    step(0, 0, 1, 0, 1, 0, 11'h400, "R7");
    chk("R7", "resumed", int'(bank_active), 0);
    // R8: power-down entry and exit
    step(1, 1, 1, 1, 0, 0, 11'h000, "R8");
    chk("R8", "pd entered", int'(power_down), 1);
    step(0, 0, 1, 1, 0, 0, 11'h001, "R8");
    chk("R8", "pd frozen", int'(bank_active), 0);
    step(1, 1, 1, 1, 1, 0, 11'h000, "R8");
    chk("R8", "pd exit", int'(power_down), 0);
    step(1, 1, 1, 1, 1, 0, 11'h000, "R8");
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      step(pick == 0, 1'($urandom), 1'($urandom), 1'($urandom), pick > 2,
           1'($urandom), 11'($urandom), "R1");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule